// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block issues the register writes that a processor core needs when it takes an exception and when a handler returns. Each cycle it looks at seven request lines (reset, undefined instruction, supervisor call, fetch abort, data abort, normal interrupt and fast interrupt), the live status word, the return address and a return command. It then drives write strobes and write data toward a banked register file. The targets are the saved-status slot and the link slot of the target mode, the live status word, and the program counter.

An entry is done as one step. The status word is copied into the saved-status slot of the target mode, and the return address goes into that mode's link slot. The mode field, the compact-instruction-state bit and the interrupt masks are rewritten, and the program counter is pointed at the vector for the cause. A return copies the current mode's saved status back into the live status word and the current mode's link value into the program counter. Every action lasts one cycle, flagged by `busy_o`, and the register file commits it at the next edge.

Top module: `exc_seq`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises, `busy_o` and all four write strobes are low.
- R2: An accepted request, sampled at clock edge N, raises `busy_o`, `sav_we_o`, `link_we_o`, `st_we_o` and `pc_we_o` for exactly the cycle after edge N. In that cycle `sav_wdata_o` equals the status word sampled at edge N.
- R3: The target mode on `bank_mode_o` and the vector offset on `pc_wdata_o` follow the cause. Reset: supervisor 0x13, offset 0x00. Undefined: undef 0x1B, 0x04. Supervisor call: supervisor 0x13, 0x08. Fetch abort: abort 0x17, 0x0C. Data abort: abort 0x17, 0x10. Normal interrupt: 0x12, 0x18. Fast interrupt: 0x11, 0x1C.
- R4: On entry the new status word keeps bits above 7 and puts the target mode in bits [4:0]. It clears bit 5 (compact-instruction state) and sets bit 7 (normal-interrupt mask). It sets bit 6 (fast-interrupt mask) for reset and fast-interrupt entries and keeps bit 6 for all other causes.
- R5: On entry `link_wdata_o` equals the `ret_addr_i` value sampled with the request.
- R6: When several requests are present together, the winner is chosen in this order: reset, data abort, fast interrupt, normal interrupt, fetch abort, undefined, supervisor call.
- R7: A normal-interrupt request is ignored while status bit 7 is set, and a fast-interrupt request while bit 6 is set. Reset is never masked.
- R8: A return command in a banked mode (0x11, 0x12, 0x13, 0x17, 0x1B) raises `busy_o`, `st_we_o` and `pc_we_o` for one cycle, with `st_wdata_o` = `saved_i` and `pc_wdata_o` = `link_i`. It leaves `sav_we_o` and `link_we_o` low.
- R9: A return command in user mode (0x10), system mode (0x1F) or any other mode encoding produces no strobe.
- R10: If an unmasked request and a return command arrive in the same cycle, the entry is taken and the return is dropped.
- R11: Requests and return commands present in the cycle where `busy_o` is high are ignored.
- R12: With `HIGH_VECTORS` = 1 the vector is 0xFFFF0000 plus the offset of R3. With the default of 0 it is the offset alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer |
| req_reset_i | input | 1 | Reset exception request |
| req_undef_i | input | 1 | Undefined-instruction request |
| req_svc_i | input | 1 | Supervisor-call request |
| req_fabort_i | input | 1 | Instruction-fetch abort request |
| req_dabort_i | input | 1 | Data-access abort request |
| req_irq_i | input | 1 | Normal interrupt request |
| req_fint_i | input | 1 | Fast interrupt request |
| eret_i | input | 1 | Exception-return command |
| status_i | input | DATA_W | Live status word |
| saved_i | input | DATA_W | Saved status of the current mode |
| link_i | input | DATA_W | Link value of the current mode |
| ret_addr_i | input | DATA_W | Return address to preserve on entry |
| busy_o | output | 1 | Action cycle marker |
| bank_mode_o | output | 5 | Target mode for the banked writes |
| sav_we_o | output | 1 | Saved-status write strobe |
| sav_wdata_o | output | DATA_W | Saved-status write data |
| link_we_o | output | 1 | Link write strobe |
| link_wdata_o | output | DATA_W | Link write data |
| st_we_o | output | 1 | Status write strobe |
| st_wdata_o | output | DATA_W | Status write data |
| pc_we_o | output | 1 | Program-counter write strobe |
| pc_wdata_o | output | DATA_W | Program-counter write data |

## Verification
The only state the block holds is the one-cycle action register. If it goes wrong, the error shows at the ports on the very next cycle. Possible symptoms are a strobe that stays up for two cycles, a missing entry after a busy cycle, a wrong mode on `bank_mode_o`, or a vector or status value that differs from the reference by a bit. Because the bench compares every output on every cycle, a wrong priority or masking decision is reported in the cycle where the wrong cause gets its strobes, and a misrouted data word is reported in the same cycle.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

   localparam int NCAUSE = 7;

   localparam int BIT_CS = 5;
   localparam int BIT_FM = 6;
   localparam int BIT_IM = 7;

   localparam logic [4:0] MD_USR = 5'h10;
   localparam logic [4:0] MD_FIN = 5'h11;
   localparam logic [4:0] MD_IRQ = 5'h12;
   localparam logic [4:0] MD_SUP = 5'h13;
   localparam logic [4:0] MD_ABT = 5'h17;
   localparam logic [4:0] MD_UND = 5'h1B;
   localparam logic [4:0] MD_SYS = 5'h1F;

   // Value equals priority rank: 0 wins.
   typedef enum logic [2:0] {
      CS_RST  = 3'd0,
      CS_DABT = 3'd1,
      CS_FIN  = 3'd2,
      CS_IRQ  = 3'd3,
      CS_FABT = 3'd4,
      CS_UND  = 3'd5,
      CS_SVC  = 3'd6
   } cause_e;

   function automatic logic [4:0] cause_mode(cause_e c);
      case (c)
         CS_RST, CS_SVC:   return MD_SUP;
         CS_DABT, CS_FABT: return MD_ABT;
         CS_FIN:           return MD_FIN;
         CS_IRQ:           return MD_IRQ;
         default:          return MD_UND;
      endcase
   endfunction

   function automatic logic [4:0] cause_off(cause_e c);
      case (c)
         CS_RST:  return 5'h00;
         CS_UND:  return 5'h04;
         CS_SVC:  return 5'h08;
         CS_FABT: return 5'h0C;
         CS_DABT: return 5'h10;
         CS_IRQ:  return 5'h18;
         default: return 5'h1C;
      endcase
   endfunction

   function automatic logic cause_fmask(cause_e c);
      return (c == CS_RST) || (c == CS_FIN);
   endfunction

   function automatic logic mode_banked(logic [4:0] m);
      return (m == MD_FIN) || (m == MD_IRQ) || (m == MD_SUP) ||
             (m == MD_ABT) || (m == MD_UND);
   endfunction

endpackage

// File: rtl/exc_seq_arb.sv
module exc_seq_arb
   import exc_seq_pkg::*;
#(
   parameter int N = NCAUSE
) (
   input  logic [N-1:0] req_i,
   input  logic         irq_mask_i,
   input  logic         fin_mask_i,
   output logic         hit_o,
   output cause_e       cause_o
);

   if (N != NCAUSE) begin : g_bad_n
      $error("exc_seq_arb: N must equal the cause count");
   end

   logic [N-1:0] elig;

   for (genvar g = 0; g < N; g++) begin : g_mask
      if (g == int'(CS_IRQ)) begin : g_irq
         assign elig[g] = req_i[g] & ~irq_mask_i;
      end else if (g == int'(CS_FIN)) begin : g_fin
         assign elig[g] = req_i[g] & ~fin_mask_i;
      end else begin : g_raw
         assign elig[g] = req_i[g];
      end
   end

   always_comb begin
      hit_o   = |elig;
      cause_o = CS_SVC;
      for (int i = N - 1; i >= 0; i--) begin
         if (elig[i]) cause_o = cause_e'(i[2:0]);
      end
   end

endmodule

// File: rtl/exc_seq_ret.sv
module exc_seq_ret
   import exc_seq_pkg::*;
(
   input  logic       eret_i,
   input  logic [4:0] mode_i,
   output logic       ret_ok_o
);

   assign ret_ok_o = eret_i & mode_banked(mode_i);

endmodule

// File: rtl/exc_seq_wb.sv
module exc_seq_wb
   import exc_seq_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit HIGH_VECTORS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_i,
   input  cause_e            cause_i,
   input  logic              ret_i,
   input  logic [DATA_W-1:0] st_i,
   input  logic [DATA_W-1:0] sav_i,
   input  logic [DATA_W-1:0] link_i,
   input  logic [DATA_W-1:0] ret_addr_i,
   output logic              busy_o,
   output logic [4:0]        bank_o,
   output logic              sav_we_o,
   output logic [DATA_W-1:0] sav_wdata_o,
   output logic              link_we_o,
   output logic [DATA_W-1:0] link_wdata_o,
   output logic              st_we_o,
   output logic [DATA_W-1:0] st_wdata_o,
   output logic              pc_we_o,
   output logic [DATA_W-1:0] pc_wdata_o
);

   localparam int HI_W = DATA_W - 16;

   logic [DATA_W-1:0] vec_base;
   logic [DATA_W-1:0] entry_st;
   logic [DATA_W-1:0] entry_pc;

   if (HIGH_VECTORS) begin : g_hivec
      assign vec_base = {{HI_W{1'b1}}, 16'h0000};
   end else begin : g_lovec
      assign vec_base = '0;
   end

   always_comb begin
      entry_st         = st_i;
      entry_st[4:0]    = cause_mode(cause_i);
      entry_st[BIT_CS] = 1'b0;
      entry_st[BIT_IM] = 1'b1;
      if (cause_fmask(cause_i)) entry_st[BIT_FM] = 1'b1;
      entry_pc = vec_base | DATA_W'(cause_off(cause_i));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_o       <= 1'b0;
         bank_o       <= '0;
         sav_we_o     <= 1'b0;
         link_we_o    <= 1'b0;
         st_we_o      <= 1'b0;
         pc_we_o      <= 1'b0;
         sav_wdata_o  <= '0;
         link_wdata_o <= '0;
         st_wdata_o   <= '0;
         pc_wdata_o   <= '0;
      end else begin
         busy_o       <= take_i | ret_i;
         bank_o       <= cause_mode(cause_i);
         sav_we_o     <= take_i;
         link_we_o    <= take_i;
         st_we_o      <= take_i | ret_i;
         pc_we_o      <= take_i | ret_i;
         sav_wdata_o  <= st_i;
         link_wdata_o <= ret_addr_i;
         st_wdata_o   <= take_i ? entry_st : sav_i;
         pc_wdata_o   <= take_i ? entry_pc : link_i;
      end
   end

endmodule

// File: rtl/exc_seq.sv
module exc_seq
   import exc_seq_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit HIGH_VECTORS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_reset_i,
   input  logic              req_undef_i,
   input  logic              req_svc_i,
   input  logic              req_fabort_i,
   input  logic              req_dabort_i,
   input  logic              req_irq_i,
   input  logic              req_fint_i,
   input  logic              eret_i,
   input  logic [DATA_W-1:0] status_i,
   input  logic [DATA_W-1:0] saved_i,
   input  logic [DATA_W-1:0] link_i,
   input  logic [DATA_W-1:0] ret_addr_i,
   output logic              busy_o,
   output logic [4:0]        bank_mode_o,
   output logic              sav_we_o,
   output logic [DATA_W-1:0] sav_wdata_o,
   output logic              link_we_o,
   output logic [DATA_W-1:0] link_wdata_o,
   output logic              st_we_o,
   output logic [DATA_W-1:0] st_wdata_o,
   output logic              pc_we_o,
   output logic [DATA_W-1:0] pc_wdata_o
);

   if (DATA_W < 16) begin : g_bad_w
      $error("exc_seq: DATA_W must be at least 16");
   end

   logic [NCAUSE-1:0] req_vec;
   logic              hit;
   cause_e            cause;
   logic              ret_ok;
   logic              take;
   logic              ret_go;

   // Bit index equals priority rank of the cause.
   assign req_vec = {req_svc_i, req_undef_i, req_fabort_i, req_irq_i,
                     req_fint_i, req_dabort_i, req_reset_i};

   exc_seq_arb #(.N(NCAUSE)) arb_i (
      .req_i      (req_vec),
      .irq_mask_i (status_i[BIT_IM]),
      .fin_mask_i (status_i[BIT_FM]),
      .hit_o      (hit),
      .cause_o    (cause)
   );

   exc_seq_ret ret_i (
      .eret_i   (eret_i),
      .mode_i   (status_i[4:0]),
      .ret_ok_o (ret_ok)
   );

   assign take   = hit & ~busy_o;
   assign ret_go = ret_ok & ~hit & ~busy_o;

   exc_seq_wb #(.DATA_W(DATA_W), .HIGH_VECTORS(HIGH_VECTORS)) wb_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .take_i       (take),
      .cause_i      (cause),
      .ret_i        (ret_go),
      .st_i         (status_i),
      .sav_i        (saved_i),
      .link_i       (link_i),
      .ret_addr_i   (ret_addr_i),
      .busy_o       (busy_o),
      .bank_o       (bank_mode_o),
      .sav_we_o     (sav_we_o),
      .sav_wdata_o  (sav_wdata_o),
      .link_we_o    (link_we_o),
      .link_wdata_o (link_wdata_o),
      .st_we_o      (st_we_o),
      .st_wdata_o   (st_wdata_o),
      .pc_we_o      (pc_we_o),
      .pc_wdata_o   (pc_wdata_o)
   );

endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_irq_i,
   input logic [DATA_W-1:0] status_i,
   input logic [DATA_W-1:0] saved_i,
   input logic [DATA_W-1:0] link_i,
   input logic [DATA_W-1:0] ret_addr_i,
   input logic              busy_o,
   input logic [4:0]        bank_mode_o,
   input logic              sav_we_o,
   input logic [DATA_W-1:0] sav_wdata_o,
   input logic              link_we_o,
   input logic [DATA_W-1:0] link_wdata_o,
   input logic              st_we_o,
   input logic [DATA_W-1:0] st_wdata_o,
   input logic              pc_we_o,
   input logic [DATA_W-1:0] pc_wdata_o
);

   AST_ONE_CYCLE_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> !busy_o);  // R2

   AST_ENTRY_ALL_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
      sav_we_o |-> (link_we_o && st_we_o && pc_we_o && busy_o));  // R2

   AST_STROBE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_we_o || pc_we_o) |-> busy_o);  // R8

   AST_SAV_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      sav_we_o |-> (sav_wdata_o == $past(status_i)));  // R2

   AST_LINK_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      link_we_o |-> (link_wdata_o == $past(ret_addr_i)));  // R5

   AST_ENTRY_STATE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      sav_we_o |-> (!st_wdata_o[5] && st_wdata_o[7] && st_wdata_o[4:0] == bank_mode_o));  // R4

   AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_we_o && !sav_we_o) |-> (st_wdata_o == $past(saved_i) && pc_wdata_o == $past(link_i)));  // R8

   AST_RET_NOT_UNBANKED: assert property (@(posedge clk) disable iff (!rst_n)
      (st_we_o && !sav_we_o) |-> ($past(status_i[4:0]) != 5'h10 && $past(status_i[4:0]) != 5'h1F));  // R9

   AST_IRQ_MASK_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
      (sav_we_o && bank_mode_o == 5'h12) |-> ($past(req_irq_i) && !$past(status_i[7])));  // R7

endmodule

bind exc_seq exc_seq_chk #(.DATA_W(DATA_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_irq_i    (req_irq_i),
   .status_i     (status_i),
   .saved_i      (saved_i),
   .link_i       (link_i),
   .ret_addr_i   (ret_addr_i),
   .busy_o       (busy_o),
   .bank_mode_o  (bank_mode_o),
   .sav_we_o     (sav_we_o),
   .sav_wdata_o  (sav_wdata_o),
   .link_we_o    (link_we_o),
   .link_wdata_o (link_wdata_o),
   .st_we_o      (st_we_o),
   .st_wdata_o   (st_wdata_o),
   .pc_we_o      (pc_we_o),
   .pc_wdata_o   (pc_wdata_o)
);

// File: tb/exc_seq_tb_top.sv
module exc_seq_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic r_rst = 0, r_und = 0, r_svc = 0, r_fab = 0, r_dab = 0, r_irq = 0, r_fin = 0, r_ret = 0;
   logic [31:0] st = 0, sv = 0, lk = 0, ra = 0;

   logic        busy, sav_we, link_we, st_we, pc_we;
   logic [4:0]  bank;
   logic [31:0] sav_d, link_d, st_d, pc_d;

   logic        h_busy, h_sav_we, h_link_we, h_st_we, h_pc_we;
   logic [4:0]  h_bank;
   logic [31:0] h_sav_d, h_link_d, h_st_d, h_pc_d;

   exc_seq dut_i (
      .clk(clk), .rst_n(rst_n), .req_reset_i(r_rst), .req_undef_i(r_und), .req_svc_i(r_svc),
      .req_fabort_i(r_fab), .req_dabort_i(r_dab), .req_irq_i(r_irq), .req_fint_i(r_fin),
      .eret_i(r_ret), .status_i(st), .saved_i(sv), .link_i(lk), .ret_addr_i(ra),
      .busy_o(busy), .bank_mode_o(bank), .sav_we_o(sav_we), .sav_wdata_o(sav_d),
      .link_we_o(link_we), .link_wdata_o(link_d), .st_we_o(st_we), .st_wdata_o(st_d),
      .pc_we_o(pc_we), .pc_wdata_o(pc_d));

   exc_seq #(.HIGH_VECTORS(1'b1)) dut_hv_i (
      .clk(clk), .rst_n(rst_n), .req_reset_i(r_rst), .req_undef_i(r_und), .req_svc_i(r_svc),
      .req_fabort_i(r_fab), .req_dabort_i(r_dab), .req_irq_i(r_irq), .req_fint_i(r_fin),
      .eret_i(r_ret), .status_i(st), .saved_i(sv), .link_i(lk), .ret_addr_i(ra),
      .busy_o(h_busy), .bank_mode_o(h_bank), .sav_we_o(h_sav_we), .sav_wdata_o(h_sav_d),
      .link_we_o(h_link_we), .link_wdata_o(h_link_d), .st_we_o(h_st_we), .st_wdata_o(h_st_d),
      .pc_we_o(h_pc_we), .pc_wdata_o(h_pc_d));

   int n_cmp = 0;
   int n_bad = 0;
   string cur_tag = "R2";

   // Reference model state: expected outputs for the cycle after each edge.
   logic        e_busy = 0, e_sav = 0, e_link = 0, e_st = 0, e_pc = 0, e_entry = 0;
   logic [4:0]  e_bank = 0;
   logic [31:0] e_svd = 0, e_lkd = 0, e_std = 0, e_pcd = 0, e_pchv = 0;
   string       e_tag = "R1";

   function automatic bit banked(logic [4:0] m);
      return m == 5'h11 || m == 5'h12 || m == 5'h13 || m == 5'h17 || m == 5'h1B;
   endfunction

   always @(posedge clk) begin
      int c;
      logic [4:0] md;
      logic [31:0] off;
      logic [31:0] ns;
      e_tag = cur_tag;
      c = -1;
      if (!rst_n || e_busy) begin
         e_busy = 0; e_sav = 0; e_link = 0; e_st = 0; e_pc = 0; e_entry = 0;
      end else begin
         if (r_rst) c = 0;
         else if (r_dab) c = 1;
         else if (r_fin && !st[6]) c = 2;
         else if (r_irq && !st[7]) c = 3;
         else if (r_fab) c = 4;
         else if (r_und) c = 5;
         else if (r_svc) c = 6;
         if (c >= 0) begin
            case (c)
               0: begin md = 5'h13; off = 32'h00; end
               1: begin md = 5'h17; off = 32'h10; end
               2: begin md = 5'h11; off = 32'h1C; end
               3: begin md = 5'h12; off = 32'h18; end
               4: begin md = 5'h17; off = 32'h0C; end
               5: begin md = 5'h1B; off = 32'h04; end
               default: begin md = 5'h13; off = 32'h08; end
            endcase
            ns = {st[31:8], 1'b1, (c == 0 || c == 2) ? 1'b1 : st[6], 1'b0, md};
            e_busy = 1; e_sav = 1; e_link = 1; e_st = 1; e_pc = 1; e_entry = 1;
            e_bank = md; e_svd = st; e_lkd = ra; e_std = ns;
            e_pcd = off; e_pchv = 32'hFFFF_0000 + off;
         end else if (r_ret && banked(st[4:0])) begin
            e_busy = 1; e_sav = 0; e_link = 0; e_st = 1; e_pc = 1; e_entry = 0;
            e_std = sv; e_pcd = lk; e_pchv = lk;
         end else begin
            e_busy = 0; e_sav = 0; e_link = 0; e_st = 0; e_pc = 0; e_entry = 0;
         end
      end
   end

   task automatic cmp(string tag, string fld, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s act=%h exp=%h", tag, fld, act, exp);
      end
   endtask

   logic chk_en = 0;
   always @(negedge clk) begin
      if (chk_en) begin
         cmp(e_tag, "busy", 32'(busy), 32'(e_busy));               // R2 R11
         cmp(e_tag, "sav_we", 32'(sav_we), 32'(e_sav));            // R2 R8
         cmp(e_tag, "link_we", 32'(link_we), 32'(e_link));         // R8 R9
         cmp(e_tag, "st_we", 32'(st_we), 32'(e_st));               // R9
         cmp(e_tag, "pc_we", 32'(pc_we), 32'(e_pc));               // R10
         if (e_sav)  cmp(e_tag, "sav_wdata", sav_d, e_svd);        // R2
         if (e_link) cmp("R5", "link_wdata", link_d, e_lkd);
         if (e_entry) cmp("R3", "bank_mode", 32'(bank), 32'(e_bank));
         if (e_st)   cmp(e_entry ? "R4" : "R8", "st_wdata", st_d, e_std);
         if (e_pc)   cmp(e_entry ? "R3" : "R8", "pc_wdata", pc_d, e_pcd);
         if (e_pc)   cmp("R12", "hv_pc_wdata", h_pc_d, e_pchv);
      end
   end

   task automatic step(logic [6:0] rq, logic rt, logic [31:0] s);
      // rq bits: 0 reset,1 dabort,2 fint,3 irq,4 fabort,5 undef,6 svc
      @(negedge clk);
      {r_svc, r_und, r_fab, r_irq, r_fin, r_dab, r_rst} = rq;
      r_ret = rt; st = s;
      sv = $urandom; lk = $urandom; ra = $urandom;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(7'h0, 1'b0, st);
   endtask

   function automatic logic [4:0] pick_mode(int k);
      case (k % 7)
         0: return 5'h10; 1: return 5'h11; 2: return 5'h12; 3: return 5'h13;
         4: return 5'h17; 5: return 5'h1B; default: return 5'h1F;
      endcase
   endfunction

   bit done = 0;
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R2 watchdog expired act=running exp=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      r_rst = 1; r_irq = 1; r_ret = 1; st = 32'h0000_0013;
      repeat (3) @(negedge clk);
      // R1: strobes quiet during reset despite active inputs
      cmp("R1", "busy_rst", 32'(busy), 0);
      cmp("R1", "we_rst", 32'({sav_we, link_we, st_we, pc_we}), 0);
      rst_n = 1;
      {r_rst, r_irq, r_ret} = 3'b000;
      chk_en = 1;

      // R2 R3 R5: each cause alone from supervisor mode, masks clear
      cur_tag = "R3";
      for (int b = 0; b < 7; b++) begin
         step(7'(1 << b), 1'b0, {24'hA5C3_00, 8'h33});
         idle(2);
      end
      // R4: fast mask kept for non-fast causes
      cur_tag = "R4";
      step(7'b0100000, 1'b0, 32'h1234_5653);
      idle(1);
      // R6: priority ladder
      cur_tag = "R6";
      step(7'b1111111, 1'b0, 32'h0000_0010); idle(1);
      step(7'b1111110, 1'b0, 32'h0000_0010); idle(1);
      step(7'b1111100, 1'b0, 32'h0000_0010); idle(1);
      step(7'b1111000, 1'b0, 32'h0000_0010); idle(1);
      step(7'b1110000, 1'b0, 32'h0000_0010); idle(1);
      step(7'b1100000, 1'b0, 32'h0000_0010); idle(1);
      // R7: masking
      cur_tag = "R7";
      step(7'b0001000, 1'b0, 32'h0000_0090); idle(1);
      step(7'b0000100, 1'b0, 32'h0000_0050); idle(1);
      step(7'b0001101, 1'b0, 32'h0000_00D0); idle(1);
      // R8: return in each banked mode
      cur_tag = "R8";
      for (int k = 1; k < 6; k++) begin
         step(7'h0, 1'b1, {27'h0, pick_mode(k)}); idle(1);
      end
      // R9: return ignored in user, system and an illegal encoding
      cur_tag = "R9";
      step(7'h0, 1'b1, 32'h0000_0010); idle(1);
      step(7'h0, 1'b1, 32'h0000_001F); idle(1);
      step(7'h0, 1'b1, 32'h0000_0000); idle(1);
      // R10: entry beats return
      cur_tag = "R10";
      step(7'b0001000, 1'b1, 32'h0000_0013); idle(1);
      // R11: request held across the busy cycle
      cur_tag = "R11";
      step(7'b0000010, 1'b0, 32'h0000_0013);
      step(7'b0000010, 1'b1, 32'h0000_0013);
      step(7'b0000010, 1'b0, 32'h0000_0013);
      idle(2);
      // Random traffic, all requirements
      cur_tag = "R6";
      for (int n = 0; n < 4000; n++) begin
         logic [6:0] rq;
         rq = 7'($urandom) & 7'($urandom) & 7'($urandom);
         step(rq, 1'($urandom), {$urandom_range(0, 32'hFFFFFF), $urandom_range(0, 3) == 0 ? 3'b000 : 3'($urandom), pick_mode($urandom_range(0, 6))});
      end
      idle(3);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule